// File: doc/BRIEF.md
# Interrupt Request Capture with Selectable Edge/Level Sensitivity

This block turns a set of raw interrupt lines into pending-request bits. Each line first passes through a two-flop synchronizer. A per-line trigger-mode bit then picks how it is captured. In level mode the pending bit tracks the synchronized input. In edge mode the pending bit is set on a low-to-high transition and then holds until the acknowledge logic clears it.

The trigger-mode register is written through a simple write port and can be read back at any time. A fixed, per-instance parameter sets which lines may become level sensitive. Bits outside that mask always store as 0, so those lines stay edge triggered. The acknowledge logic pulses a per-line clear strobe. That strobe clears only edge-mode requests, so a level-mode line held high stays pending. Priority resolution, masking and the processor interface lie outside this block.

Top module: `irq_capture`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) has its pending bit equal to its synchronized input level.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets its pending bit only when the synchronized level is 1 and the previously sampled level was 0. Once cleared, a line held high does not set again.
- R3: An edge-mode pending bit stays set while no clear strobe arrives, even after the input returns low.
- R4: A trigger-mode write stores the write data ANDed with the LEVEL_MASK parameter (default 8'hF8). The readback output returns that stored value, so writing 8'hFF reads back 8'hF8 and writing 8'h5A reads back 8'h58.
- R5: A clear strobe on a line clears its pending bit only in edge mode. In level mode the strobe has no effect.
- R6: If a new rising edge and a clear strobe for the same edge-mode line occur in the same cycle, the pending bit stays set.
- R7: Synchronous active-high reset clears the pending bits, the sampled-level history, the synchronizer and the trigger-mode register to 0.
- R8: An input change first shows on the pending bit after the third rising clock edge: two synchronizer stages, then the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw asynchronous interrupt lines |
| tm_wr_en | input | 1 | Trigger-mode register write strobe |
| tm_wr_data | input | N_LINES | Trigger-mode write data (1 = level, 0 = edge) |
| ack_clr | input | N_LINES | Per-line clear strobe from acknowledge logic |
| irr | output | N_LINES | Pending request vector |
| tm_rd | output | N_LINES | Trigger-mode register readback |

## Verification
The bench walks mixed vectors where edge lines 0 to 2 and level lines 3 to 7 change together. This catches a design that lets clears drop level requests, or that lets edge bits fall when the input falls. A directed collision test asserts the clear in exactly the cycle a new edge is captured. A design that gives the clear priority would lose that request. A held-high line checked after its clear catches a design that retriggers on level rather than on transition. Checks of the mask on writes, the three-edge latency and a mid-run reset catch an unmasked trigger register, a missing synchronizer stage and history that survives reset.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic pend;
        logic hist;
    } line_state_t;

    function automatic logic rise_seen(input logic cur, input logic hist);
        return cur & ~hist;
    endfunction

    function automatic line_state_t next_state(input trig_e       mode,
                                               input logic        cur,
                                               input line_state_t st,
                                               input logic        clr);
        line_state_t n;
        n.hist = cur;
        if (mode == TRIG_LEVEL)
            n.pend = cur;
        else
            n.pend = rise_seen(cur, st.hist) | (st.pend & ~clr);
        return n;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q[0] <= '0;
        else
            chain_q[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain_q[s] <= '0;
                else
                    chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign q = chain_q[LAST];
endmodule

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] MASK  = WIDTH'(8'hF8)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wr_data & MASK;
    end

    // R4
    tm_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mode_q == ($past(wr_data) & MASK)));

    // R4
    tm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q));

    // R7
    tm_reset_chk: assert property (@(posedge clk)
        rst |=> (mode_q == '0));
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_capture_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_lvl,
    input  logic lvl_now,
    input  logic clr,
    output logic pend
);
    line_state_t st_q;
    line_state_t st_d;
    trig_e       mode;

    assign mode = mode_lvl ? TRIG_LEVEL : TRIG_EDGE;

    always_comb st_d = next_state(mode, lvl_now, st_q, clr);

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R1
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mode_lvl |=> (pend == $past(lvl_now)));

    // R5
    level_clr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_lvl && clr && lvl_now) |=> pend);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_lvl && pend && !clr) |=> pend);

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_lvl && lvl_now && !st_q.hist) |=> pend);

    // R2
    edge_no_retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_lvl && !pend && st_q.hist) |=> !pend);

    // R7
    cell_reset_chk: assert property (@(posedge clk)
        rst |=> (!pend && !st_q.hist));
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int                 N_LINES    = 8,
    parameter logic [N_LINES-1:0] LEVEL_MASK = N_LINES'(8'hF8),
    parameter int                 SYNC_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               tm_wr_en,
    input  logic [N_LINES-1:0] tm_wr_data,
    input  logic [N_LINES-1:0] ack_clr,
    output logic [N_LINES-1:0] irr,
    output logic [N_LINES-1:0] tm_rd
);
    logic [N_LINES-1:0] lvl_sync;
    logic [N_LINES-1:0] mode_q;

    irq_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (lvl_sync)
    );

    trig_mode_reg #(
        .WIDTH (N_LINES),
        .MASK  (LEVEL_MASK)
    ) u_tm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tm_wr_en),
        .wr_data (tm_wr_data),
        .mode_q  (mode_q)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            irq_line_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .mode_lvl (mode_q[i]),
                .lvl_now  (lvl_sync[i]),
                .clr      (ack_clr[i]),
                .pend     (irr[i])
            );
        end
    endgenerate

    assign tm_rd = mode_q;

    // R4
    tm_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((tm_rd & ~LEVEL_MASK) == '0));

    // R7
    irr_reset_chk: assert property (@(posedge clk)
        rst |=> (irr == '0));
endmodule

// File: tb/irq_capture_tb.sv
`timescale 1ns/1ps
module irq_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       tm_wr_en = 1'b0;
    logic [7:0] tm_wr_data = '0;
    logic [7:0] ack_clr = '0;
    logic [7:0] irr;
    logic [7:0] tm_rd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_capture dut_i (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .tm_wr_en   (tm_wr_en),
        .tm_wr_data (tm_wr_data),
        .ack_clr    (ack_clr),
        .irr        (irr),
        .tm_rd      (tm_rd)
    );

    // {irq level, clear mask, expected before clear, expected after clear}
    // trigger mode 8'hF8: lines 0..2 edge, 3..7 level
    localparam logic [31:0] VEC [8] = '{
        {8'h00, 8'h00, 8'h00, 8'h00},
        {8'h0F, 8'hFF, 8'h0F, 8'h08},
        {8'h00, 8'h00, 8'h00, 8'h00},
        {8'h05, 8'h01, 8'h05, 8'h04},
        {8'h00, 8'h04, 8'h04, 8'h00},
        {8'hF0, 8'hFF, 8'hF0, 8'hF0},
        {8'h33, 8'h02, 8'h33, 8'h31},
        {8'h00, 8'h00, 8'h01, 8'h01}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tm_write(input logic [7:0] v);
        tm_wr_en = 1'b1;
        tm_wr_data = v;
        cycles(1);
        tm_wr_en = 1'b0;
    endtask

    task automatic pulse_clr(input logic [7:0] m);
        ack_clr = m;
        cycles(1);
        ack_clr = '0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        check("R7 reset irr", irr, 8'h00);
        check("R7 reset tm", tm_rd, 8'h00);

        tm_write(8'hFF);
        check("R4 tm mask FF", tm_rd, 8'hF8);
        tm_write(8'h5A);
        check("R4 tm mask 5A", tm_rd, 8'h58);
        tm_write(8'hFF);

        irq_in = 8'h08;
        cycles(2);
        check("R8 not yet at edge 2", irr, 8'h00);
        cycles(1);
        check("R8 visible at edge 3", irr, 8'h08);
        irq_in = 8'h00;
        cycles(3);

        for (int k = 0; k < 8; k++) begin
            irq_in = VEC[k][31:24];
            cycles(3);
            check($sformatf("R1 R3 vec%0d before clear", k), irr, VEC[k][15:8]);
            pulse_clr(VEC[k][23:16]);
            check($sformatf("R5 vec%0d after clear", k), irr, VEC[k][7:0]);
        end

        tm_write(8'h00);
        irq_in = 8'h00;
        pulse_clr(8'hFF);
        cycles(3);
        irq_in = 8'h01;
        cycles(3);
        check("R2 edge set", irr, 8'h01);
        irq_in = 8'h00;
        cycles(3);
        check("R3 edge held after fall", irr, 8'h01);
        irq_in = 8'h01;
        cycles(2);
        pulse_clr(8'h01);
        check("R6 edge wins over clear", irr, 8'h01);
        pulse_clr(8'h01);
        check("R5 edge cleared", irr, 8'h00);
        cycles(4);
        check("R2 held high no retrigger", irr, 8'h00);

        tm_write(8'hFF);
        irq_in = 8'hF2;
        cycles(3);
        check("R1 pre-reset state", irr, 8'hF2);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        check("R7 mid reset irr", irr, 8'h00);
        check("R7 mid reset tm", tm_rd, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule